// File: doc/BRIEF.md
# NAND Flash Device Command Front End

This block is the device side of a byte-wide NAND flash interface. A host drives an 8-bit bus together with a command-latch strobe, an address-latch strobe and an active-low write enable. On every rising edge of write enable the byte is classified as a command, an address or a data byte, according to which latch strobe is high. The decoded commands operate a page load buffer and a small array of full-size pages, so the block can be exercised on its own. The array holds a few pages of 528 bytes each: 512 main bytes and 16 spare bytes.

The supported operations are page read, page program with partial loading, block erase, identification read, status read and reset. The column where a read or a load starts is chosen by one of three pointer commands. The first half of the page is persistent. The second half applies to one operation only. The spare area stays selected until another pointer command is given. Ready/busy is driven low while an array operation runs, for a number of clock cycles fixed by a parameter. Active-low read enable steps through output bytes on its rising edges.

Top module: `nand_cmd_front`

## Requirements
- R1: On a rising edge of `we_n_i`, the byte on `io_i` is a command when `cle_i`=1 and `ale_i`=0, an address when `ale_i`=1 and `cle_i`=0, and a data byte when both are 0. Nothing is captured at any other time.
- R2: After reset `rdy_o`=1 and the array holds FFh everywhere. The interface is in array-read mode at column 0 of page 0 with the first-half pointer selected.
- R3: Pointer commands set the start column from the first address byte `a`. Command 00h selects column `a`. Command 01h selects 256+`a` for the next operation only, and the pointer then returns to the first half. Command 50h selects 512+`a[3:0]` and stays selected until 00h, 01h or FFh.
- R4: A read is a pointer command followed by three address bytes: the column byte, a page byte (page index in its low bits) and a high byte that is ignored. Each `re_n_i` rising edge then advances the column. `io_o` shows the addressed byte, or FFh at columns 528 and above.
- R5: Command 80h, three address bytes, N data bytes at consecutive columns, then command 10h programs the page. Each byte is ANDed into the array. Bytes that were not loaded are unchanged. Data bytes past column 527 are ignored.
- R6: Command 60h, two address bytes (page byte, high byte) and then D0h erase the block given by the page index divided by the pages per block. Every byte of that block becomes FFh. Other blocks are unchanged.
- R7: Command 90h followed by address 00h selects identification output. Successive reads return the manufacturer code, then the device code, then FFh.
- R8: Command FFh is accepted at any time. It aborts a running operation and leaves the array unchanged. `rdy_o`=1 from the cycle after it is captured. It returns to array-read mode with the first-half pointer and clears the fail flag.
- R9: `rdy_o` goes low on the clock edge that captures the byte starting a read, program or erase. It stays low for exactly T_RD, T_PG or T_ER cycles.
- R10: Command 70h selects status output, and it is accepted while busy. The status byte is {bit7 = `wp_n_i`, bit6 = ready, bits 5..1 = 0, bit0 = fail}.
- R11: With `wp_n_i`=0, confirming a program (10h) or an erase (D0h) does not start it. The array is untouched, `rdy_o` stays 1 and the fail flag is set. The next accepted confirm clears the flag.
- R12: While busy, every command other than 70h and FFh is ignored, and so are address, data and read strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all bus lines are sampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| cle_i | input | 1 | Command latch strobe |
| ale_i | input | 1 | Address latch strobe |
| we_n_i | input | 1 | Active-low write enable; bytes are taken on its rising edge |
| re_n_i | input | 1 | Active-low read enable; its rising edge steps the output |
| wp_n_i | input | 1 | Active-low write protect |
| io_i | input | 8 | Byte from the host |
| io_o | output | 8 | Byte to the host |
| io_oe_o | output | 1 | Output enable, high while read enable is low |
| rdy_o | output | 1 | Ready (1) / busy (0) |

## Verification
The assertions check the following on every cycle: that a reset command brings ready back on the next cycle, that a protected confirm never lowers ready, that commands arriving during busy leave the sequencing state alone, that the column never passes one beyond the page end, and that the busy counter rises and falls around its start and finish. Other behaviour can only be shown by the bench's scenarios: the exact busy length, the AND merge of partial loads, the pointer lifetimes of the three areas, erase confined to one block, the identification sequence, and an aborted program leaving its page untouched. The bench shows these by reading the array back against its own model.

// File: rtl/nand_pkg.sv
package nand_pkg;

    typedef enum logic [1:0] {
        OUT_ARRAY  = 2'd0,
        OUT_IDENT  = 2'd1,
        OUT_STATUS = 2'd2
    } out_mode_e;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_ADR_RD  = 3'd1,
        PH_ADR_PG  = 3'd2,
        PH_LOAD    = 3'd3,
        PH_ADR_ER  = 3'd4,
        PH_ER_CONF = 3'd5,
        PH_ADR_ID  = 3'd6
    } phase_e;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_PROG  = 2'd2,
        OP_ERASE = 2'd3
    } op_e;

    localparam logic [7:0] CMD_PTR_LO   = 8'h00;
    localparam logic [7:0] CMD_PTR_HI   = 8'h01;
    localparam logic [7:0] CMD_PTR_SP   = 8'h50;
    localparam logic [7:0] CMD_LOAD     = 8'h80;
    localparam logic [7:0] CMD_PROG     = 8'h10;
    localparam logic [7:0] CMD_ER_SETUP = 8'h60;
    localparam logic [7:0] CMD_ER_GO    = 8'hD0;
    localparam logic [7:0] CMD_IDENT    = 8'h90;
    localparam logic [7:0] CMD_STATUS   = 8'h70;
    localparam logic [7:0] CMD_RESET    = 8'hFF;

endpackage

// File: rtl/nand_edge.sv
module nand_edge #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl_i;
        rise_o = lvl_i & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/nand_busy_timer.sv
module nand_busy_timer #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             abort_i,
    output logic             busy_o,
    output logic             done_o
);
    logic [LEN_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (abort_i)           cnt_d = '0;
        else if (start_i)      cnt_d = len_i;
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
        busy_o = (cnt_q != '0);
        done_o = (cnt_q == LEN_W'(1)) && !abort_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_start_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !abort_i && (len_i != '0) |=> busy_o);
    assert_done_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !start_i |=> !busy_o);
endmodule

// File: rtl/nand_store.sv
module nand_store #(
    parameter int PAGE_BYTES    = 528,
    parameter int NUM_PAGES     = 4,
    parameter int PAGES_PER_BLK = 2,
    parameter int COL_W         = 10,
    parameter int PG_W          = 2,
    parameter int BLK_W         = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             buf_clr_i,
    input  logic             buf_we_i,
    input  logic [COL_W-1:0] buf_col_i,
    input  logic [7:0]       buf_din_i,
    input  logic             commit_i,
    input  logic [PG_W-1:0]  page_i,
    input  logic             erase_i,
    input  logic [BLK_W-1:0] blk_i,
    input  logic [COL_W-1:0] rd_col_i,
    output logic [7:0]       rd_data_o
);
    localparam int CELLS = NUM_PAGES * PAGE_BYTES;

    logic [7:0] mem_q [CELLS];
    logic [7:0] buf_q [PAGE_BYTES];

    always_comb begin
        if (int'(rd_col_i) < PAGE_BYTES)
            rd_data_o = mem_q[int'(page_i) * PAGE_BYTES + int'(rd_col_i)];
        else
            rd_data_o = 8'hFF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < PAGE_BYTES; i++) buf_q[i] <= 8'hFF;
        end else if (buf_clr_i) begin
            for (int i = 0; i < PAGE_BYTES; i++) buf_q[i] <= 8'hFF;
        end else if (buf_we_i && int'(buf_col_i) < PAGE_BYTES) begin
            buf_q[int'(buf_col_i)] <= buf_din_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < CELLS; i++) mem_q[i] <= 8'hFF;
        end else if (commit_i) begin
            for (int i = 0; i < PAGE_BYTES; i++)
                mem_q[int'(page_i) * PAGE_BYTES + i] <=
                    mem_q[int'(page_i) * PAGE_BYTES + i] & buf_q[i];
        end else if (erase_i) begin
            for (int p = 0; p < NUM_PAGES; p++)
                if (p / PAGES_PER_BLK == int'(blk_i))
                    for (int i = 0; i < PAGE_BYTES; i++)
                        mem_q[p * PAGE_BYTES + i] <= 8'hFF;
        end
    end

    // R5 / R6: a program commit and an erase never complete together
    always_comb begin
        if (rst_n) assert_commit_erase_excl_R6: assert (!(commit_i && erase_i));
    end
endmodule

// File: rtl/nand_cmd_front.sv
module nand_cmd_front
    import nand_pkg::*;
#(
    parameter int          PAGE_BYTES    = 528,
    parameter int          MAIN_BYTES    = 512,
    parameter int          HALF_BYTES    = 256,
    parameter int          SPARE_BYTES   = 16,
    parameter int          NUM_PAGES     = 4,
    parameter int          PAGES_PER_BLK = 2,
    parameter int          T_RD          = 6,
    parameter int          T_PG          = 20,
    parameter int          T_ER          = 30,
    parameter logic [7:0]  MFR_CODE      = 8'h4D,
    parameter logic [7:0]  DEV_CODE      = 8'hE6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cle_i,
    input  logic       ale_i,
    input  logic       we_n_i,
    input  logic       re_n_i,
    input  logic       wp_n_i,
    input  logic [7:0] io_i,
    output logic [7:0] io_o,
    output logic       io_oe_o,
    output logic       rdy_o
);
    localparam int COL_W = $clog2(PAGE_BYTES + 1);
    localparam int PG_W  = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;
    localparam int PIB_W = $clog2(PAGES_PER_BLK);
    localparam int BLK_W = (PG_W > PIB_W) ? PG_W - PIB_W : 1;
    localparam int SP_W  = $clog2(SPARE_BYTES);
    localparam int T_MAX = (T_ER > T_PG) ? ((T_ER > T_RD) ? T_ER : T_RD)
                                         : ((T_PG > T_RD) ? T_PG : T_RD);
    localparam int TMR_W = $clog2(T_MAX + 1);

    typedef struct packed {
        out_mode_e        mode;
        phase_e           phase;
        logic [1:0]       acnt;
        logic [COL_W-1:0] col;
        logic [PG_W-1:0]  row;
        logic             ptr_hi;
        logic             ptr_sp;
        op_e              op;
        logic             fail;
        logic [1:0]       id_idx;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [1:0]       rise;
    logic             we_rise, re_rise;
    logic             cmd_stb, adr_stb, dat_stb;
    logic             busy, done;
    logic             tmr_start, tmr_abort;
    logic [TMR_W-1:0] tmr_len;
    logic             buf_clr, buf_we;
    logic             commit, erase;
    logic [7:0]       rd_data;
    logic [BLK_W-1:0] erase_blk;

    nand_edge #(.W(2)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  ({re_n_i, we_n_i}),
        .rise_o (rise)
    );

    assign we_rise = rise[0];
    assign re_rise = rise[1];
    assign cmd_stb = we_rise &&  cle_i && !ale_i;
    assign adr_stb = we_rise && !cle_i &&  ale_i;
    assign dat_stb = we_rise && !cle_i && !ale_i;

    nand_busy_timer #(.LEN_W(TMR_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (tmr_start),
        .len_i   (tmr_len),
        .abort_i (tmr_abort),
        .busy_o  (busy),
        .done_o  (done)
    );

    function automatic logic [COL_W-1:0] start_col(input logic hi, input logic sp,
                                                   input logic [7:0] a);
        if (sp)      return COL_W'(MAIN_BYTES) + COL_W'(a[SP_W-1:0]);
        else if (hi) return COL_W'(HALF_BYTES) + COL_W'(a);
        else         return COL_W'(a);
    endfunction

    always_comb begin
        ctl_d     = ctl_q;
        tmr_start = 1'b0;
        tmr_abort = 1'b0;
        tmr_len   = '0;
        buf_clr   = 1'b0;
        buf_we    = 1'b0;

        if (done) ctl_d.op = OP_NONE;

        if (cmd_stb) begin
            if (io_i == CMD_RESET) begin
                tmr_abort    = 1'b1;
                ctl_d.mode   = OUT_ARRAY;
                ctl_d.phase  = PH_IDLE;
                ctl_d.acnt   = '0;
                ctl_d.ptr_hi = 1'b0;
                ctl_d.ptr_sp = 1'b0;
                ctl_d.op     = OP_NONE;
                ctl_d.fail   = 1'b0;
            end else if (io_i == CMD_STATUS) begin
                ctl_d.mode = OUT_STATUS;
            end else if (!busy) begin
                case (io_i)
                    CMD_PTR_LO, CMD_PTR_HI, CMD_PTR_SP: begin
                        ctl_d.ptr_hi = (io_i == CMD_PTR_HI);
                        ctl_d.ptr_sp = (io_i == CMD_PTR_SP);
                        ctl_d.phase  = PH_ADR_RD;
                        ctl_d.acnt   = '0;
                        ctl_d.mode   = OUT_ARRAY;
                    end
                    CMD_LOAD: begin
                        ctl_d.phase = PH_ADR_PG;
                        ctl_d.acnt  = '0;
                        buf_clr     = 1'b1;
                    end
                    CMD_PROG: begin
                        if (ctl_q.phase == PH_LOAD) begin
                            ctl_d.phase = PH_IDLE;
                            if (wp_n_i) begin
                                tmr_start  = 1'b1;
                                tmr_len    = TMR_W'(T_PG);
                                ctl_d.op   = OP_PROG;
                                ctl_d.fail = 1'b0;
                            end else begin
                                ctl_d.fail = 1'b1;
                            end
                        end
                    end
                    CMD_ER_SETUP: begin
                        ctl_d.phase = PH_ADR_ER;
                        ctl_d.acnt  = '0;
                    end
                    CMD_ER_GO: begin
                        if (ctl_q.phase == PH_ER_CONF) begin
                            ctl_d.phase = PH_IDLE;
                            if (wp_n_i) begin
                                tmr_start  = 1'b1;
                                tmr_len    = TMR_W'(T_ER);
                                ctl_d.op   = OP_ERASE;
                                ctl_d.fail = 1'b0;
                            end else begin
                                ctl_d.fail = 1'b1;
                            end
                        end
                    end
                    CMD_IDENT: begin
                        ctl_d.phase = PH_ADR_ID;
                    end
                    default: ;
                endcase
            end
        end else if (adr_stb && !busy) begin
            case (ctl_q.phase)
                PH_ADR_RD, PH_ADR_PG: begin
                    ctl_d.acnt = ctl_q.acnt + 2'd1;
                    if (ctl_q.acnt == 2'd0) begin
                        ctl_d.col = start_col(ctl_q.ptr_hi, ctl_q.ptr_sp, io_i);
                    end else if (ctl_q.acnt == 2'd1) begin
                        ctl_d.row = PG_W'(io_i);
                    end else begin
                        ctl_d.ptr_hi = 1'b0;
                        if (ctl_q.phase == PH_ADR_RD) begin
                            ctl_d.phase = PH_IDLE;
                            ctl_d.op    = OP_READ;
                            tmr_start   = 1'b1;
                            tmr_len     = TMR_W'(T_RD);
                        end else begin
                            ctl_d.phase = PH_LOAD;
                        end
                    end
                end
                PH_ADR_ER: begin
                    ctl_d.acnt = ctl_q.acnt + 2'd1;
                    if (ctl_q.acnt == 2'd0) ctl_d.row   = PG_W'(io_i);
                    else                    ctl_d.phase = PH_ER_CONF;
                end
                PH_ADR_ID: begin
                    ctl_d.phase = PH_IDLE;
                    if (io_i == 8'h00) begin
                        ctl_d.mode   = OUT_IDENT;
                        ctl_d.id_idx = '0;
                    end
                end
                default: ;
            endcase
        end else if (dat_stb && !busy) begin
            if (ctl_q.phase == PH_LOAD && int'(ctl_q.col) < PAGE_BYTES) begin
                buf_we    = 1'b1;
                ctl_d.col = ctl_q.col + 1'b1;
            end
        end else if (re_rise && !busy && ctl_q.phase == PH_IDLE) begin
            if (ctl_q.mode == OUT_ARRAY && int'(ctl_q.col) < PAGE_BYTES)
                ctl_d.col = ctl_q.col + 1'b1;
            else if (ctl_q.mode == OUT_IDENT && ctl_q.id_idx < 2'd2)
                ctl_d.id_idx = ctl_q.id_idx + 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign commit    = done && (ctl_q.op == OP_PROG);
    assign erase     = done && (ctl_q.op == OP_ERASE);
    assign erase_blk = BLK_W'(ctl_q.row >> PIB_W);

    nand_store #(
        .PAGE_BYTES    (PAGE_BYTES),
        .NUM_PAGES     (NUM_PAGES),
        .PAGES_PER_BLK (PAGES_PER_BLK),
        .COL_W         (COL_W),
        .PG_W          (PG_W),
        .BLK_W         (BLK_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .buf_clr_i (buf_clr),
        .buf_we_i  (buf_we),
        .buf_col_i (ctl_q.col),
        .buf_din_i (io_i),
        .commit_i  (commit),
        .page_i    (ctl_q.row),
        .erase_i   (erase),
        .blk_i     (erase_blk),
        .rd_col_i  (ctl_q.col),
        .rd_data_o (rd_data)
    );

    always_comb begin
        case (ctl_q.mode)
            OUT_IDENT:  io_o = (ctl_q.id_idx == 2'd0) ? MFR_CODE :
                               (ctl_q.id_idx == 2'd1) ? DEV_CODE : 8'hFF;
            OUT_STATUS: io_o = {wp_n_i, !busy, 5'b00000, ctl_q.fail};
            default:    io_o = rd_data;
        endcase
    end

    assign io_oe_o = !re_n_i;
    assign rdy_o   = !busy;

    assert_reset_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb && io_i == CMD_RESET |=> rdy_o);
    assert_busy_ignores_R12: assert property (@(posedge clk) disable iff (!rst_n)
        busy && cmd_stb && io_i != CMD_STATUS && io_i != CMD_RESET
        |=> ctl_q.phase == $past(ctl_q.phase) && ctl_q.mode == $past(ctl_q.mode));
    assert_col_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ctl_q.col) <= PAGE_BYTES);
    assert_wp_no_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_o && cmd_stb && !wp_n_i && (io_i == CMD_PROG || io_i == CMD_ER_GO) |=> rdy_o);
endmodule

// File: tb/sim_nand_cmd_front.sv
module sim_nand_cmd_front;
    localparam int PB = 528;
    localparam int NP = 4;
    localparam int T_RD = 6, T_PG = 20, T_ER = 30;
    localparam logic [7:0] MFR = 8'h4D, DEV = 8'hE6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cle = 0, ale = 0, we_n = 1, re_n = 1, wp_n = 1;
    logic [7:0] io_in = 8'h00;
    logic [7:0] io_out;
    logic io_oe, rdy;

    always #10 clk = ~clk;

    nand_cmd_front u0 (
        .clk(clk), .rst_n(rst_n), .cle_i(cle), .ale_i(ale), .we_n_i(we_n),
        .re_n_i(re_n), .wp_n_i(wp_n), .io_i(io_in), .io_o(io_out),
        .io_oe_o(io_oe), .rdy_o(rdy)
    );

    int n_chk = 0, n_bad = 0;
    bit fin = 0;
    logic [7:0] ref_mem [NP*PB];
    int bm_area = 0;
    logic [7:0] dat [16];

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int colcalc(input int area, input logic [7:0] a);
        if (area == 2) return 512 + int'(a[3:0]);
        if (area == 1) return 256 + int'(a);
        return int'(a);
    endfunction

    function automatic logic [7:0] exp_b(input int pg, input int c);
        return (c < PB) ? ref_mem[pg*PB + c] : 8'hFF;
    endfunction

    task automatic send(input logic c, input logic a, input logic [7:0] b);
        @(negedge clk); cle = c; ale = a; io_in = b; we_n = 0;
        @(negedge clk); we_n = 1;
        @(negedge clk); cle = 0; ale = 0;
    endtask

    task automatic cmd(input logic [7:0] b);
        send(1, 0, b);
        if (b == 8'h00 || b == 8'hFF) bm_area = 0;
        else if (b == 8'h01) bm_area = 1;
        else if (b == 8'h50) bm_area = 2;
    endtask

    task automatic addr3(input logic [7:0] a, input int pg, output int c);
        c = colcalc(bm_area, a);
        send(0, 1, a); send(0, 1, 8'(pg)); send(0, 1, 8'h00);
        if (bm_area == 1) bm_area = 0;
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (!rdy && n < 2000) begin n++; @(negedge clk); end
    endtask

    task automatic rd_byte(output logic [7:0] b);
        @(negedge clk); re_n = 0;
        @(negedge clk); b = io_out; re_n = 1;
        @(negedge clk);
    endtask

    task automatic prog(input logic [7:0] a, input int pg, input int len, output int n);
        int c;
        cmd(8'h80); addr3(a, pg, c);
        for (int k = 0; k < len; k++) send(0, 0, dat[k]);
        cmd(8'h10); wait_ready(n);
        if (wp_n)
            for (int k = 0; k < len; k++)
                if (c + k < PB) ref_mem[pg*PB + c + k] &= dat[k];
    endtask

    task automatic read_at(input logic [7:0] ptr, input logic [7:0] a, input int pg, output int c);
        int n;
        cmd(ptr); addr3(a, pg, c); wait_ready(n);
    endtask

    task automatic erase_blk(input int blk, output int n);
        cmd(8'h60); send(0, 1, 8'(blk*2)); send(0, 1, 8'h00); cmd(8'hD0); wait_ready(n);
        if (wp_n) for (int i = 0; i < 2*PB; i++) ref_mem[blk*2*PB + i] = 8'hFF;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!fin) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int c, n, s;
        logic [7:0] b;
        s = $urandom(32'h1D5E);
        for (int i = 0; i < NP*PB; i++) ref_mem[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R2: reset state
        chk("R2 ready after reset", rdy, 1);
        rd_byte(b); chk("R2 power-up read", b, 8'hFF);
        // R10: status after reset
        cmd(8'h70); rd_byte(b); chk("R10 status idle", b, 8'hC0);

        // R1/R5/R9: directed partial program
        dat[0] = 8'h12; dat[1] = 8'h34; dat[2] = 8'h56;
        cmd(8'h00); prog(8'd5, 1, 3, n);
        chk("R9 program busy cycles", n, T_PG);
        read_at(8'h00, 8'd4, 1, c);
        for (int k = 0; k < 5; k++) begin
            rd_byte(b); chk("R4 R5 read back", b, exp_b(1, c + k));
        end

        // R3: second-half pointer is one-shot
        dat[0] = 8'hA5; cmd(8'h01); prog(8'd3, 2, 1, n);
        dat[0] = 8'h5A; prog(8'd3, 2, 1, n);
        read_at(8'h00, 8'd3, 2, c); rd_byte(b); chk("R3 first half after one-shot", b, 8'h5A);
        read_at(8'h01, 8'd3, 2, c); rd_byte(b); chk("R3 second half", b, 8'hA5);
        // R3: spare pointer is sticky
        dat[0] = 8'h3C; cmd(8'h50); prog(8'd2, 3, 1, n);
        dat[0] = 8'hC3; prog(8'd4, 3, 1, n);
        read_at(8'h50, 8'd4, 3, c); rd_byte(b); chk("R3 spare sticky", b, 8'hC3);
        chk("R3 spare column model", b, exp_b(3, 516));

        // R5/R4: load past page end ignored, reads past end give FFh
        for (int k = 0; k < 5; k++) dat[k] = 8'h0F + 8'(k);
        cmd(8'h00); prog(8'd13, 0, 5, n);   // area A col 13 is not the end; use spare
        cmd(8'h50); prog(8'd13, 0, 5, n);   // columns 525..529
        read_at(8'h50, 8'd14, 0, c);
        for (int k = 0; k < 3; k++) begin
            rd_byte(b); chk("R4 R5 page end", b, exp_b(0, c + k));
        end

        // Random programs with read-back against the model (R3 R4 R5)
        for (int it = 0; it < 14; it++) begin
            int pg, ar, len;
            logic [7:0] a, ptr;
            pg = $urandom_range(NP-1); ar = $urandom_range(2);
            len = $urandom_range(1, 8); a = 8'($urandom);
            for (int k = 0; k < len; k++) dat[k] = 8'($urandom);
            ptr = (ar == 2) ? 8'h50 : (ar == 1) ? 8'h01 : 8'h00;
            cmd(ptr); prog(a, pg, len, n);
            read_at(ptr, a, pg, c);
            for (int k = 0; k < len + 1; k++) begin
                rd_byte(b); chk("R3 R4 R5 random read", b, exp_b(pg, c + k));
            end
        end

        // R6/R9: erase block 0, block 1 untouched
        erase_blk(0, n); chk("R9 erase busy cycles", n, T_ER);
        read_at(8'h00, 8'd5, 1, c); rd_byte(b); chk("R6 erased byte", b, 8'hFF);
        read_at(8'h01, 8'd3, 2, c); rd_byte(b); chk("R6 other block kept", b, exp_b(2, 259));

        // R7: identification
        cmd(8'h90); send(0, 1, 8'h00);
        rd_byte(b); chk("R7 manufacturer", b, MFR);
        rd_byte(b); chk("R7 device", b, DEV);
        rd_byte(b); chk("R7 after codes", b, 8'hFF);

        // R12: commands during busy ignored (mode stays identification)
        cmd(8'h90); send(0, 1, 8'h00);
        cmd(8'h60); send(0, 1, 8'h02); send(0, 1, 8'h00); cmd(8'hD0);
        cmd(8'h00); send(0, 1, 8'h00); send(0, 1, 8'h00); send(0, 1, 8'h00);
        wait_ready(n);
        for (int i = 0; i < 2*PB; i++) ref_mem[2*PB + i] = 8'hFF;
        rd_byte(b); chk("R12 busy command ignored", b, MFR);

        // R10: status while busy
        cmd(8'h00); send(0, 1, 8'h00); send(0, 1, 8'h02); send(0, 1, 8'h00);
        wait_ready(n);
        cmd(8'h60); send(0, 1, 8'h02); send(0, 1, 8'h00); cmd(8'hD0);
        cmd(8'h70); rd_byte(b); chk("R10 status busy", b, 8'h80);
        wait_ready(n); rd_byte(b); chk("R10 status done", b, 8'hC0);

        // R8: reset aborts a program
        dat[0] = 8'h00;
        cmd(8'h00); cmd(8'h80); addr3(8'd7, 3, c); send(0, 0, 8'h00); cmd(8'h10);
        chk("R9 busy after confirm", rdy, 0);
        repeat (3) @(negedge clk);
        cmd(8'hFF); chk("R8 ready after reset cmd", rdy, 1);
        rd_byte(b); chk("R8 read mode after reset", b, exp_b(3, 7));
        read_at(8'h00, 8'd7, 3, c); rd_byte(b); chk("R8 aborted page unchanged", b, exp_b(3, 7));

        // R11: write protect
        wp_n = 0; dat[0] = 8'h00;
        cmd(8'h00); prog(8'd9, 3, 1, n);
        chk("R11 no busy when protected", n, 0);
        cmd(8'h70); rd_byte(b); chk("R11 status fail protected", b, 8'h41);
        erase_blk(1, n); chk("R11 erase blocked", n, 0);
        read_at(8'h00, 8'd9, 3, c); rd_byte(b); chk("R11 array untouched", b, exp_b(3, 9));
        wp_n = 1; dat[0] = 8'hF0;
        cmd(8'h00); prog(8'd9, 3, 1, n);
        cmd(8'h70); rd_byte(b); chk("R11 fail cleared", b, 8'hC0);
        read_at(8'h00, 8'd9, 3, c); rd_byte(b); chk("R5 after protect lifted", b, exp_b(3, 9));

        // R1: latch strobes without a write-enable edge capture nothing
        cmd(8'h70);
        @(negedge clk); cle = 1; io_in = 8'h90;
        @(negedge clk); cle = 0;
        rd_byte(b); chk("R1 no edge no capture", b, 8'hC0);

        fin = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule